// File: doc/BRIEF.md
# Time-Multiplexed Multichannel PWM Generator

This block drives a bank of independent pulse-width modulated outputs (64 by default) from a single shared update datapath. A free-running slot counter on the fast master clock visits the channels one after another, giving each exactly one clock cycle per round. In that cycle the channel's stored state, a period counter and the duty value in force, is read from slot-addressed storage, advanced by the shared incrementer and comparator, and written back. The registered output bit of that channel is refreshed in the same cycle.

A host loads duty values through a simple write port that names a channel, a 9-bit duty and a strobe. A loaded value is held as pending and only takes over when the channel's counter next wraps to zero, so a period in progress is never cut short or stretched. The state storage can be built as a synchronous RAM that is read one slot ahead, or as a circulating shift register whose head entry is the channel being served. Both give identical outputs.

Top module: `tdm_pwm_bank`

## Requirements
- R1: After reset is released, the k-th rising clock edge (counting from 0) serves channel k mod NUM_CH. An output bit changes only on an edge that serves its own channel.
- R2: Each channel's counter starts at 0 after reset, advances by one on each edge that serves it, and wraps from 255 to 0. A PWM period therefore lasts 256 rounds, which is 256*NUM_CH clock cycles.
- R3: On the edge that serves a channel, its output becomes 1 if the counter value before that edge is less than the channel's active duty, and 0 otherwise. Over any window of 256*NUM_CH cycles with an unchanged duty D (0 to 255), the output is high for exactly D*NUM_CH cycles.
- R4: A channel whose active duty is 0 keeps its output at 0.
- R5: A channel whose active duty is 256 or more (up to 511) keeps its output at 1.
- R6: A duty written to a channel becomes active only on the edge that serves the channel while its counter is 0. Until that edge the previous duty stays in force.
- R7: When wr_en is high at a rising edge, wr_duty is stored as the pending duty of channel wr_ch. Of several writes before a period start, the last one is the one that becomes active.
- R8: While rst is high at a rising edge, the slot counter, every channel counter, every active and pending duty and every output are cleared to 0. After release, every output stays 0 until a non-zero duty is written and becomes active.
- R9: The shift-register storage variant produces the same outputs on every cycle as the RAM variant under the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Duty write strobe |
| wr_ch | input | $clog2(NUM_CH) | Channel selected by a duty write |
| wr_duty | input | 9 | Duty value: 0 is always low, 256 or more is always high |
| pwm_out | output | NUM_CH | One registered PWM output bit per channel |

## Verification
The properties assume that rst is held high from time zero through at least one rising edge, so that the slot counter, the storage and the outputs start from known values. They also assume that wr_ch names an existing channel and that the write inputs are stable around each rising edge. The stimulus meets these conditions: it holds reset for several cycles at start-up, changes the write inputs only on falling edges, and selects channels only from 0 to NUM_CH-1. A mid-run reset is applied on a falling edge and is held for several edges.

// File: rtl/pwm_tdm_pkg.sv
`timescale 1ns/1ps
package pwm_tdm_pkg;

    // Counter width sets the PWM period (2**CNT_W rounds per period).
    localparam int CNT_W  = 8;
    localparam int DUTY_W = CNT_W + 1;
    localparam int PERIOD = 1 << CNT_W;

    // Per-channel state kept in slot storage.
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DUTY_W-1:0] act;
    } chan_state_t;

    // Storage implementation selector.
    typedef enum logic {
        STORE_RAM   = 1'b0,
        STORE_SHIFT = 1'b1
    } store_kind_e;

    // Output level for a counter value against a duty.
    function automatic logic pwm_level(input logic [CNT_W-1:0] c,
                                       input logic [DUTY_W-1:0] d);
        return ({1'b0, c} < d);
    endfunction

endpackage

// File: rtl/pwm_slot_timer.sv
`timescale 1ns/1ps
module pwm_slot_timer #(
    parameter int NUM_CH = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    output logic [$clog2(NUM_CH)-1:0] slot,
    output logic [$clog2(NUM_CH)-1:0] slot_next
);
    localparam int SLOT_W = $clog2(NUM_CH);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_CH - 1);

    always_comb begin
        slot_next = (slot == LAST) ? '0 : slot + SLOT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) slot <= '0;
        else     slot <= slot_next;
    end
endmodule

// File: rtl/pwm_state_store.sv
`timescale 1ns/1ps
module pwm_state_store
    import pwm_tdm_pkg::*;
#(
    parameter int          NUM_CH = 64,
    parameter store_kind_e STORE  = STORE_RAM
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [$clog2(NUM_CH)-1:0] rd_addr,
    input  chan_state_t               wr_data,
    output chan_state_t               cur
);
    localparam int SLOT_W = $clog2(NUM_CH);

    generate
        if (STORE == STORE_RAM) begin : g_ram
            // Synchronous RAM read one slot ahead; the write pointer is the
            // address whose data currently sits in the read register.
            chan_state_t       mem [NUM_CH];
            chan_state_t       q;
            logic [SLOT_W-1:0] wr_ptr;

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < NUM_CH; i++) mem[i] <= '0;
                    q      <= '0;
                    wr_ptr <= '0;
                end else begin
                    mem[wr_ptr] <= wr_data;
                    q           <= mem[rd_addr];
                    wr_ptr      <= rd_addr;
                end
            end
            assign cur = q;
        end else begin : g_shift
            // Circulating register chain; entry 0 is the served channel.
            chan_state_t sh [NUM_CH];
            logic        unused_rd;

            assign unused_rd = ^rd_addr;

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < NUM_CH; i++) sh[i] <= '0;
                end else begin
                    for (int i = 0; i < NUM_CH - 1; i++) sh[i] <= sh[i+1];
                    sh[NUM_CH-1] <= wr_data;
                end
            end
            assign cur = sh[0];
        end
    endgenerate
endmodule

// File: rtl/pwm_duty_bank.sv
`timescale 1ns/1ps
module pwm_duty_bank
    import pwm_tdm_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [$clog2(NUM_CH)-1:0] wr_ch,
    input  logic [DUTY_W-1:0]         wr_duty,
    input  logic [$clog2(NUM_CH)-1:0] rd_ch,
    output logic [DUTY_W-1:0]         rd_duty
);
    logic [DUTY_W-1:0] pend [NUM_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CH; i++) pend[i] <= '0;
        end else if (wr_en && (int'(wr_ch) < NUM_CH)) begin
            pend[wr_ch] <= wr_duty;
        end
    end

    assign rd_duty = pend[rd_ch];
endmodule

// File: rtl/pwm_chan_engine.sv
`timescale 1ns/1ps
module pwm_chan_engine
    import pwm_tdm_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [$clog2(NUM_CH)-1:0] slot,
    input  chan_state_t               cur,
    input  logic [DUTY_W-1:0]         pend_duty,
    output chan_state_t               wb,
    output logic [DUTY_W-1:0]         eff_duty,
    output logic [NUM_CH-1:0]         pwm_out
);
    // Shared update: duty swap only at period start, then count.
    always_comb begin
        eff_duty = (cur.cnt == '0) ? pend_duty : cur.act;
        wb.cnt   = cur.cnt + CNT_W'(1);
        wb.act   = eff_duty;
    end

    // Only the served channel's output bit is rewritten.
    always_ff @(posedge clk) begin
        if (rst) pwm_out       <= '0;
        else     pwm_out[slot] <= pwm_level(cur.cnt, eff_duty);
    end
endmodule

// File: rtl/tdm_pwm_bank.sv
`timescale 1ns/1ps
module tdm_pwm_bank
    import pwm_tdm_pkg::*;
#(
    parameter int          NUM_CH = 64,
    parameter store_kind_e STORE  = STORE_RAM
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [$clog2(NUM_CH)-1:0] wr_ch,
    input  logic [DUTY_W-1:0]         wr_duty,
    output logic [NUM_CH-1:0]         pwm_out
);
    localparam int SLOT_W = $clog2(NUM_CH);

    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] slot_next;
    chan_state_t       cur_st;
    chan_state_t       wb_st;
    logic [DUTY_W-1:0] pend_duty;
    logic [DUTY_W-1:0] eff_duty;

    pwm_slot_timer #(.NUM_CH(NUM_CH)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .slot_next (slot_next)
    );

    pwm_state_store #(.NUM_CH(NUM_CH), .STORE(STORE)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (slot_next),
        .wr_data (wb_st),
        .cur     (cur_st)
    );

    pwm_duty_bank #(.NUM_CH(NUM_CH)) u_duty (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_duty (wr_duty),
        .rd_ch   (slot),
        .rd_duty (pend_duty)
    );

    pwm_chan_engine #(.NUM_CH(NUM_CH)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .cur       (cur_st),
        .pend_duty (pend_duty),
        .wb        (wb_st),
        .eff_duty  (eff_duty),
        .pwm_out   (pwm_out)
    );
endmodule

// File: rtl/tdm_pwm_bank_chk.sv
`timescale 1ns/1ps
module tdm_pwm_bank_chk
    import pwm_tdm_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input logic                      clk,
    input logic                      rst,
    input logic [$clog2(NUM_CH)-1:0] slot,
    input chan_state_t               cur,
    input chan_state_t               wb,
    input logic [DUTY_W-1:0]         eff_duty,
    input logic [NUM_CH-1:0]         pwm_out
);
    localparam logic [NUM_CH-1:0] ONE_HOT0 = NUM_CH'(1);

    // R1: only the bit of the channel served on the last edge may move
    a_r1_own_slot: assert property (@(posedge clk) disable iff (rst)
        ((pwm_out ^ $past(pwm_out)) & ~(ONE_HOT0 << $past(slot))) == '0);

    // R8: a reset edge leaves outputs and slot cleared
    a_r8_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (pwm_out == '0 && slot == '0));

    // R4: zero duty drives the served bit low
    a_r4_zero_low: assert property (@(posedge clk) disable iff (rst)
        (eff_duty == '0) |=> !pwm_out[$past(slot)]);

    // R5: full duty drives the served bit high
    a_r5_full_high: assert property (@(posedge clk) disable iff (rst)
        (eff_duty >= DUTY_W'(PERIOD)) |=> pwm_out[$past(slot)]);

    // R2: counter written back wraps to zero after its top value
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (cur.cnt == '1) |-> (wb.cnt == '0));

    // R6: away from period start the active duty is carried unchanged
    a_r6_duty_hold: assert property (@(posedge clk) disable iff (rst)
        (cur.cnt != '0) |-> (wb.act == cur.act));
endmodule

bind tdm_pwm_bank tdm_pwm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .slot     (slot),
    .cur      (cur_st),
    .wb       (wb_st),
    .eff_duty (eff_duty),
    .pwm_out  (pwm_out)
);

// File: tb/tdm_pwm_bank_tb.sv
`timescale 1ns/1ps
module tdm_pwm_bank_tb;
    import pwm_tdm_pkg::*;

    localparam int NCH  = 64;
    localparam int SW   = $clog2(NCH);
    localparam int PER  = 256 * NCH;   // cycles per PWM period
    localparam int WDOG = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [SW-1:0]     wr_ch = '0;
    logic [DUTY_W-1:0] wr_duty = '0;
    logic [NCH-1:0]    pwm_out;
    logic [NCH-1:0]    pwm_sr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int ecnt  = 0;

    always #2 clk = ~clk;

    tdm_pwm_bank #(.NUM_CH(NCH), .STORE(STORE_RAM)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_duty(wr_duty), .pwm_out(pwm_out));

    tdm_pwm_bank #(.NUM_CH(NCH), .STORE(STORE_SHIFT)) u_dut_shift (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_duty(wr_duty), .pwm_out(pwm_sr));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int duty_of(input int i);
        case (i)
            0:  return 0;
            1:  return 256;
            2:  return 1;
            3:  return 255;
            4:  return 128;
            5:  return 10;
            7:  return 100;
            63: return 511;
            default: return (i * 37) % 300;
        endcase
    endfunction

    // Edges counted since reset release.
    always @(posedge clk) begin
        if (rst) ecnt <= 0;
        else     ecnt <= ecnt + 1;
    end

    // Reference model and scoreboard queue.
    typedef struct {
        logic [NCH-1:0] vec;
        int             slot;
        bit             in_rst;
    } exp_t;
    exp_t exp_q[$];

    int             pend_m [NCH];
    int             act_m  [NCH];
    int             cnt_m  [NCH];
    int             slot_m = 0;
    logic [NCH-1:0] vec_m  = '0;

    always @(posedge clk) begin
        exp_t it;
        int s;
        s = slot_m;
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                pend_m[i] = 0; act_m[i] = 0; cnt_m[i] = 0;
            end
            slot_m = 0;
            vec_m  = '0;
        end else begin
            if (cnt_m[s] == 0) act_m[s] = pend_m[s];
            vec_m[s] = (cnt_m[s] < act_m[s]);
            cnt_m[s] = (cnt_m[s] + 1) % 256;
            slot_m   = (slot_m + 1) % NCH;
            if (wr_en) pend_m[int'(wr_ch)] = int'(wr_duty);
        end
        it.vec = vec_m; it.slot = s; it.in_rst = rst;
        exp_q.push_back(it);
    end

    // Monitor: compares both variants every cycle.
    logic [NCH-1:0] prev_out = '0;
    always @(negedge clk) begin
        exp_t it;
        logic [NCH-1:0] mask;
        if (exp_q.size() > 0 && !done) begin
            it = exp_q.pop_front();
            check(pwm_out == it.vec, "R3", "output vector vs model", pwm_out, it.vec);
            check(pwm_sr == it.vec, "R9", "shift variant vs model", pwm_sr, it.vec);
            if (!it.in_rst) begin
                mask = ~(NCH'(1) << it.slot);
                check(((pwm_out ^ prev_out) & mask) == '0, "R1",
                      "bit moved outside own slot", pwm_out ^ prev_out, '0);
            end
            prev_out = pwm_out;
        end
    end

    task automatic wait_ecnt(input int target);
        while (ecnt != target) @(negedge clk);
    endtask

    task automatic window_check(input int start, input bit after_update);
        int hi [NCH];
        int want;
        string tag;
        for (int c = 0; c < NCH; c++) hi[c] = 0;
        wait_ecnt(start);
        repeat (PER) begin
            for (int c = 0; c < NCH; c++) hi[c] += int'(pwm_out[c]);
            @(negedge clk);
        end
        for (int c = 0; c < NCH; c++) begin
            want = duty_of(c);
            tag  = "R3";
            if (after_update && c == 5) begin want = 200; tag = "R6"; end
            if (after_update && c == 6) begin want = 90;  tag = "R7"; end
            if (want == 0) tag = "R4";
            if (want >= 256) begin want = 256; tag = "R5"; end
            check(hi[c] == want * NCH, tag, $sformatf("high cycles ch%0d", c),
                  64'(hi[c]), 64'(want * NCH));
        end
    endtask

    initial begin
        int hi5;
        // R8: reset state
        repeat (5) @(negedge clk);
        check(pwm_out == '0, "R8", "outputs during reset", pwm_out, '0);
        check(pwm_sr == '0, "R8", "shift outputs during reset", pwm_sr, '0);
        rst = 1'b0;

        // R7: program every channel
        for (int i = 0; i < NCH; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_ch = SW'(i); wr_duty = DUTY_W'(duty_of(i));
        end
        @(negedge clk);
        wr_en = 1'b0;

        // R3 R4 R5: steady window across periods 1 and 2
        window_check(PER + NCH, 1'b0);

        // R6: mid-period update of ch5; R7: double write to ch6
        wait_ecnt(2 * PER + 128 * NCH);
        wr_en = 1'b1; wr_ch = SW'(5); wr_duty = DUTY_W'(200);
        @(negedge clk);
        wr_ch = SW'(6); wr_duty = DUTY_W'(50);
        @(negedge clk);
        wr_duty = DUTY_W'(90);
        @(negedge clk);
        wr_en = 1'b0;
        hi5 = 0;
        while (ecnt != 3 * PER + 5) begin
            hi5 += int'(pwm_out[5]);
            @(negedge clk);
        end
        check(hi5 == 0, "R6", "new duty applied before period end", 64'(hi5), 64'(0));

        // R6 R7 R3: window across periods 3 and 4
        window_check(3 * PER + NCH, 1'b1);

        // R8: mid-run reset clears everything, duties included
        wait_ecnt(4 * PER + 100);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(pwm_out == '0, "R8", "outputs after mid-run reset", pwm_out, '0);
        rst = 1'b0;
        repeat (2 * NCH) begin
            @(negedge clk);
            check(pwm_out == '0, "R8", "outputs stay low after reset", pwm_out, '0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule